// File: doc/BRIEF.md
# Gated Frequency Counter with Serial Frame Output

This block measures the frequency of a sensor oscillator whose rate follows a capacitive sensor. It counts the oscillator's rising edges, delivered as single-cycle strobes in the system clock domain, over a window bounded by strobes from a slow timebase, around 5 Hz. When a window closes, the block takes a snapshot of the count and clears the counter so the next window starts.

The snapshot goes into a 10-bit asynchronous serial frame and leaves on a TX line. The frame is paced by a bit-rate strobe of about 2.4 kHz. The frame is built in a register that shifts toward its most significant end. It holds a low start bit, then the count with the most significant bit first, then a high stop bit.

A busy flag covers the time from the snapshot to the end of the stop bit. The counter also has an active-low count enable and a full flag. The full flag is high while the count sits at its ceiling.

Top module: `gated_freq_tx`

## Requirements
- R1: After reset, tx_out is 1, busy is 0 and cnt_full is 0.
- R2: Each system clock cycle with sense_pulse high and cnt_en_n low raises the count by one.
- R3: While cnt_en_n is 1, sense_pulse strobes leave the count unchanged.
- R4: The count stops at 255 and does not wrap. cnt_full is 1 exactly while the count is 255, and stays 1 until a window closes.
- R5: A gate_tick seen while busy is 0 closes the window. It captures the count, clears the counter and sets busy in the next cycle. A sense_pulse in that same cycle counts as the first edge of the new window.
- R6: A gate_tick seen while busy is 1 has no effect. The counter keeps running, and its total goes out with the next accepted window.
- R7: A frame is 10 bits: a start bit of 0, then count bits 7 down to 0, then a stop bit of 1.
- R8: After a capture, tx_out stays 1 until the next baud_tick. Each frame bit then starts on one baud_tick and lasts until the next. busy falls on the baud_tick that ends the stop bit, and tx_out is 1 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_pulse | input | 1 | One-cycle strobe per sensor oscillator rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| gate_tick | input | 1 | One-cycle strobe from the window timebase |
| baud_tick | input | 1 | One-cycle strobe at the serial bit rate |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | High from capture to end of stop bit |
| cnt_full | output | 1 | High while the count is at its ceiling |

## Verification
The bench drives windows of 0 pulses, 5 pulses, a mixed bit pattern, and more pulses than the counter can hold. An overflow that wraps would transmit a small value instead of 255.

It also sends strobes while the count is disabled, and gate strobes while a frame is on the line. A design that ignored the enable would send a larger count. A design that reloaded during a frame would corrupt the frame or lose the pulses that arrived meanwhile.

A sense strobe is placed in the same cycle as a window close. That edge must show up in the next frame, not in this one and not in neither.

Bits are sampled mid-period, and busy is checked at the exact stop-bit boundary. This catches a reversed bit order, a start bit that begins before a bit-rate strobe, and an extra or missing bit period.

// File: rtl/gft_pkg.sv
// Shared types for the gated frequency counter and serial transmitter.
package gft_pkg;

    // Serializer phases: idle, loaded and waiting for a bit boundary, shifting.
    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_ARM  = 2'd1,
        SER_SEND = 2'd2
    } ser_state_e;

endpackage

// File: rtl/gft_pulse_counter.sv
// Saturating pulse counter.
// What it does: counts enabled sense strobes, holds at all-ones, and can be
// cleared for a new window. A strobe in the clear cycle becomes the first
// count of the new window.
// What it assumes: strobes are single-cycle enables in the clk domain, and
// clr_n is a one-cycle synchronous request.
module gft_pulse_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         en_n,
    input  logic         clr_n,
    output logic [W-1:0] count,
    output logic         carry
);
    localparam logic [W-1:0] CEIL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic hit;

    // Purpose: qualify a strobe with the active-low enable.
    always_comb hit = strobe && !en_n;

    // Purpose: update the count with clear, increment or saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!clr_n) begin
            count <= hit ? ONE : '0;
        end else if (hit && (count != CEIL)) begin
            count <= count + ONE;
        end
    end

    // Purpose: flag terminal count.
    always_comb carry = (count == CEIL);

    // R4: once at the ceiling, stay there until a clear.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CEIL && clr_n) |=> (count == CEIL));

    // R3: with enable off and no clear, the count holds.
    a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && clr_n) |=> $stable(count));

    // R5: a clear leaves at most one count behind.
    a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n) |=> (count[W-1:1] == '0));

endmodule

// File: rtl/gft_gate_ctrl.sv
// Window close control.
// What it does: accepts a gate strobe only while the serializer is idle.
// It then asks for a frame load and a counter clear in the same cycle, and
// builds the frame as {start 0, count MSB first, stop 1}.
// What it assumes: busy comes from a register, so load has no loop.
module gft_gate_ctrl #(
    parameter int W  = 8,
    parameter int FW = W + 2
) (
    input  logic          gate_tick,
    input  logic          busy,
    input  logic [W-1:0]  count,
    output logic          load,
    output logic          clr_n,
    output logic [FW-1:0] frame
);
    // Purpose: accept a window close only when the transmitter is free.
    always_comb load = gate_tick && !busy;

    // Purpose: clear the counter in the cycle its value is captured.
    always_comb clr_n = !load;

    // Purpose: lay out the frame so the top bit leaves first.
    always_comb frame = {1'b0, count, 1'b1};

endmodule

// File: rtl/gft_serializer.sv
// Left-shifting frame serializer.
// What it does: takes a frame on load, waits for the next bit-rate strobe,
// then sends the top bit for one strobe period at a time. It ends after FW
// bits.
// What it assumes: baud_tick is a single-cycle enable, and load arrives only
// while busy is low.
module gft_serializer
    import gft_pkg::*;
#(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          baud_tick,
    output logic          tx,
    output logic          busy
);
    localparam int IW = $clog2(FW);
    localparam logic [IW-1:0] LAST = IW'(FW - 1);

    ser_state_e    state_q;
    logic [FW-1:0] shreg_q;
    logic [IW-1:0] idx_q;

    // Purpose: sequence load, bit-boundary alignment and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            shreg_q <= '1;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SER_IDLE: begin
                    if (load) begin
                        shreg_q <= frame;
                        state_q <= SER_ARM;
                    end
                end
                SER_ARM: begin
                    if (baud_tick) begin
                        idx_q   <= '0;
                        state_q <= SER_SEND;
                    end
                end
                SER_SEND: begin
                    if (baud_tick) begin
                        if (idx_q == LAST) begin
                            shreg_q <= '1;
                            state_q <= SER_IDLE;
                        end else begin
                            shreg_q <= {shreg_q[FW-2:0], 1'b1};
                            idx_q   <= idx_q + IW'(1);
                        end
                    end
                end
                default: state_q <= SER_IDLE;
            endcase
        end
    end

    // Purpose: drive the line from the shifter top only while sending.
    always_comb tx = (state_q == SER_SEND) ? shreg_q[FW-1] : 1'b1;

    // Purpose: report any phase other than idle as busy.
    always_comb busy = (state_q != SER_IDLE);

    // R8: the line changes only on a bit-rate strobe.
    a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx));

    // R5: a load makes the block busy in the next cycle.
    a_r5_busy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R6: without a strobe, a busy transmitter stays busy.
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> busy);

    // R8: the line is high whenever the transmitter is idle.
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

endmodule

// File: rtl/gated_freq_tx.sv
// Gated frequency counter with serial frame output.
// What it does: counts sensor strobes, captures and clears the count on an
// accepted gate strobe, and sends it as a start/data/stop frame paced by the
// bit-rate strobe.
// What it assumes: all strobes are single-cycle enables in clk's domain.
module gated_freq_tx #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_pulse,
    input  logic cnt_en_n,
    input  logic gate_tick,
    input  logic baud_tick,
    output logic tx_out,
    output logic busy,
    output logic cnt_full
);
    localparam int FRAME_W = CNT_W + 2;

    logic [CNT_W-1:0]   count;
    logic               load;
    logic               clr_n;
    logic [FRAME_W-1:0] frame;

    gft_pulse_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sense_pulse),
        .en_n   (cnt_en_n),
        .clr_n  (clr_n),
        .count  (count),
        .carry  (cnt_full)
    );

    gft_gate_ctrl #(.W(CNT_W), .FW(FRAME_W)) u_gate (
        .gate_tick (gate_tick),
        .busy      (busy),
        .count     (count),
        .load      (load),
        .clr_n     (clr_n),
        .frame     (frame)
    );

    gft_serializer #(.FW(FRAME_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .frame     (frame),
        .baud_tick (baud_tick),
        .tx        (tx_out),
        .busy      (busy)
    );

endmodule

// File: tb/gated_freq_tx_tb.sv
module gated_freq_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_pulse = 1'b0;
    logic cnt_en_n = 1'b0;
    logic gate_tick = 1'b0;
    logic baud_tick = 1'b0;
    logic tx_out, busy, cnt_full;

    int n_checks = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    gated_freq_tx u_dut (
        .clk(clk), .rst_n(rst_n), .sense_pulse(sense_pulse), .cnt_en_n(cnt_en_n),
        .gate_tick(gate_tick), .baud_tick(baud_tick), .tx_out(tx_out),
        .busy(busy), .cnt_full(cnt_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bit-rate strobe: one cycle in four.
    initial begin
        forever begin
            repeat (3) begin @(negedge clk); baud_tick = 1'b0; end
            @(negedge clk); baud_tick = rst_n;
        end
    end

    // Driver: sense strobes, with the model updated per R2/R3/R4.
    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sense_pulse = 1'b1;
            if (!cnt_en_n && model < 255) model++;
            @(negedge clk); sense_pulse = 1'b0;
        end
    endtask

    // Driver: gate strobe; pushes the expected frame when accepted (R5/R6).
    task automatic gate(input bit with_pulse);
        bit acc;
        @(negedge clk);
        acc = !busy;
        gate_tick = 1'b1;
        sense_pulse = with_pulse;
        if (acc) begin
            exp_q.push_back(8'(model));
            model = (with_pulse && !cnt_en_n) ? 1 : 0;
        end else if (with_pulse && !cnt_en_n && model < 255) begin
            model++;
        end
        @(negedge clk);
        gate_tick = 1'b0;
        sense_pulse = 1'b0;
        if (acc) begin
            chk(busy === 1'b1, "R5 busy after capture", busy, 1);
            chk(tx_out === 1'b1, "R8 line high before bit boundary", tx_out, 1);
        end else begin
            chk(busy === 1'b1, "R6 ignored gate keeps frame", busy, 1);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: detect the start bit, sample mid-bit, compare with the queue.
    initial begin
        logic [7:0] exp_v;
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", 1, 0);
                    exp_v = 8'h00;
                end else begin
                    exp_v = exp_q.pop_front();
                end
                repeat (2) @(negedge clk);
                chk(tx_out === 1'b0, "R7 start bit", tx_out, 0);
                got = '0;
                for (int k = 0; k < 8; k++) begin
                    repeat (4) @(negedge clk);
                    got = {got[6:0], tx_out};
                end
                chk(got === exp_v, "R7 data bits MSB first", got, exp_v);
                repeat (4) @(negedge clk);
                chk(tx_out === 1'b1, "R7 stop bit", tx_out, 1);
                repeat (2) @(negedge clk);
                chk(busy === 1'b0, "R8 busy ends with stop bit", busy, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(tx_out === 1'b1, "R1 tx idle in reset", tx_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(cnt_full === 1'b0, "R1 full after reset", cnt_full, 0);
        chk(tx_out === 1'b1, "R1 tx after reset", tx_out, 1);
        model = 0;

        // R2: small count.
        pulses(5);
        gate(1'b0);
        wait_idle();

        // R2: empty window.
        gate(1'b0);
        wait_idle();

        // R2: mixed bit pattern 0xA5.
        pulses(165);
        gate(1'b0);
        wait_idle();

        // R3: disabled strobes are not counted.
        cnt_en_n = 1'b1;
        pulses(10);
        cnt_en_n = 1'b0;
        pulses(3);
        gate(1'b0);
        wait_idle();

        // R4: saturation and full flag.
        pulses(254);
        chk(cnt_full === 1'b0, "R4 full below ceiling", cnt_full, 0);
        pulses(1);
        chk(cnt_full === 1'b1, "R4 full at ceiling", cnt_full, 1);
        pulses(45);
        chk(cnt_full === 1'b1, "R4 full held past ceiling", cnt_full, 1);
        gate(1'b0);
        chk(cnt_full === 1'b0, "R4 full cleared by capture", cnt_full, 0);
        wait_idle();

        // R5: strobe in the capture cycle joins the new window.
        pulses(2);
        gate(1'b1);
        wait_idle();
        gate(1'b0);
        wait_idle();

        // R6: gate while busy is ignored; pulses carry into the next frame.
        pulses(4);
        gate(1'b0);
        pulses(7);
        gate(1'b0);
        chk(exp_q.size() <= 1, "R6 no extra capture", exp_q.size(), 1);
        wait_idle();
        gate(1'b0);
        wait_idle();

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule